// File: doc/BRIEF.md
# Subtract and Compare Flag Unit

This block is a 32-bit arithmetic slice for the subtract family of a processor pipeline. In a single cycle it forms a difference from two operands under an operation code. It also forms the next values of four condition flags: zero, negative, carry (borrow) and signed overflow. It raises one strobe when the difference should go back to a register and another when the flags should be written.

Seven operations are supported:

- plain subtract;
- subtract with borrow, which takes the stored carry flag as an extra borrow-in;
- three scaled subtracts, where the second operand is shifted left by one, two or three bits first;
- reverse subtract;
- compare, which changes only the flags.

A per-instruction flag-enable input decides whether the writing operations also update the flags. Compare always updates them.

A small flag register is kept inside the block. It holds the flags across instructions, so a borrow from one subtract feeds the next subtract-with-borrow. Its contents are visible on an output port.

Top module: `sub_flag_unit`

## Requirements
- R1: Operation code 0 (SUB) drives `result` = `opnd_a` − `opnd_b` modulo 2^32 and raises `result_we` in the same cycle.
- R2: Operation code 1 (SBC) drives `result` = `opnd_a` − `opnd_b` − C, where C is the stored carry flag (`flags_q[1]`), and raises `result_we`.
- R3: Operation codes 2, 3 and 4 (scaled subtract) drive `result` = `opnd_a` − (`opnd_b` << k), with k = 1, 2 and 3 respectively. The shift is logical with zero fill, bits leaving the top are dropped, and `result_we` is raised.
- R4: Operation code 5 (RSUB) drives `result` = `opnd_b` − `opnd_a`. In the flag equations the two operands take each other's roles, and `result_we` is raised.
- R5: Operation code 6 (CMP) computes `opnd_a` − `opnd_b`, keeps `result_we` low and raises `flags_we` whatever the value of `flag_en`.
- R6: Operation code 7 is idle: both `result_we` and `flags_we` stay low.
- R7: The zero flag (`flags_next[3]`) is 1 exactly when the 32-bit difference is zero. The negative flag (`flags_next[2]`) equals bit 31 of the difference.
- R8: The carry flag (`flags_next[1]`) is the borrow out of the top bit. This is bit 31 of (~m & s) | (~m & d) | (d & s), where m is the minuend and s is the subtrahend after any shift or swap, and d is the difference. For SBC, m and s are the unmodified operands and d is the final difference.
- R9: The overflow flag (`flags_next[0]`) is bit 31 of (m ^ d) & (m ^ s), with m, s and d defined as in R8.
- R10: For operation codes 0 to 5, `flags_we` is high only when `flag_en` is high. With `flag_en` low, the stored flags keep their values.
- R11: `flags_q`, laid out {Z,N,C,V} from bit 3 to bit 0, resets to 0. It loads `flags_next` on the rising clock edge when `flags_we` is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 3 | Operation select, codes 0 to 7 |
| flag_en | input | 1 | Per-instruction flag update enable |
| result | output | 32 | Difference for the selected operation |
| result_we | output | 1 | Result write strobe |
| flags_next | output | 4 | Next flags {Z,N,C,V} |
| flags_we | output | 1 | Flag write strobe |
| flags_q | output | 4 | Stored flags {Z,N,C,V} |

## Verification
The only state is the stored flag word, so most errors show up at the ports right away.

A wrong difference, shift or operand swap appears on `result` and `flags_next` in the same cycle the operation is applied. A wrong enable decode appears on the strobes in that same cycle.

A corrupted or missed flag load appears on `flags_q` one edge later. It also shows a cycle later in the result of the next subtract-with-borrow, which reads the stored carry. For that reason the bench chains borrows across back-to-back operations.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_SUB  = 3'd0,
        OP_SBC  = 3'd1,
        OP_SUB1 = 3'd2,
        OP_SUB2 = 3'd3,
        OP_SUB3 = 3'd4,
        OP_RSUB = 3'd5,
        OP_CMP  = 3'd6,
        OP_IDLE = 3'd7
    } op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic       active;
        logic       swap;
        logic [1:0] shamt;
        logic       use_cin;
        logic       wr_res;
        logic       flags_always;
    } dec_t;

endpackage

// File: rtl/sfu_decode.sv
module sfu_decode
    import sfu_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    output dec_t           dec
);

    always_comb begin
        dec = '0;
        unique case (op_e'(op_code))
            OP_SUB: begin
                dec.active = 1'b1;
                dec.wr_res = 1'b1;
            end
            OP_SBC: begin
                dec.active  = 1'b1;
                dec.wr_res  = 1'b1;
                dec.use_cin = 1'b1;
            end
            OP_SUB1: begin
                dec.active = 1'b1;
                dec.wr_res = 1'b1;
                dec.shamt  = 2'd1;
            end
            OP_SUB2: begin
                dec.active = 1'b1;
                dec.wr_res = 1'b1;
                dec.shamt  = 2'd2;
            end
            OP_SUB3: begin
                dec.active = 1'b1;
                dec.wr_res = 1'b1;
                dec.shamt  = 2'd3;
            end
            OP_RSUB: begin
                dec.active = 1'b1;
                dec.wr_res = 1'b1;
                dec.swap   = 1'b1;
            end
            OP_CMP: begin
                dec.active       = 1'b1;
                dec.flags_always = 1'b1;
            end
            OP_IDLE: begin
                dec = '0;
            end
            default: begin
                dec = '0;
            end
        endcase
    end

endmodule

// File: rtl/sfu_operand_prep.sv
module sfu_operand_prep #(
    parameter int W         = 32,
    parameter int MAX_SHIFT = 3
) (
    input  logic [W-1:0]                       a,
    input  logic [W-1:0]                       b,
    input  logic                               swap,
    input  logic [$clog2(MAX_SHIFT+1)-1:0]     shamt,
    output logic [W-1:0]                       minu,
    output logic [W-1:0]                       subt
);

    localparam int NCAND = MAX_SHIFT + 1;

    logic [W-1:0] src_b;
    logic [W-1:0] cand [NCAND];

    assign src_b = swap ? a : b;

    // One candidate per shift amount, logical zero-fill
    for (genvar k = 0; k < NCAND; k++) begin : g_shift
        assign cand[k] = src_b << k;
    end

    always_comb begin
        subt = cand[0];
        for (int k = 0; k < NCAND; k++) begin
            if (int'(shamt) == k) begin
                subt = cand[k];
            end
        end
    end

    assign minu = swap ? b : a;

endmodule

// File: rtl/sfu_sub_core.sv
module sfu_sub_core
    import sfu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] minu,
    input  logic [W-1:0] subt,
    input  logic         bin,
    output logic [W-1:0] diff,
    output flags_t       flg
);

    localparam int MSB = W - 1;

    logic [W-1:0] brw_vec;
    logic [W-1:0] ovf_vec;

    assign diff    = minu - subt - {{(W-1){1'b0}}, bin};
    assign brw_vec = (~minu & subt) | (~minu & diff) | (diff & subt);
    assign ovf_vec = (minu ^ diff) & (minu ^ subt);

    always_comb begin
        flg.z = (diff == '0);
        flg.n = diff[MSB];
        flg.c = brw_vec[MSB];
        flg.v = ovf_vec[MSB];
    end

endmodule

// File: rtl/sfu_flag_file.sv
module sfu_flag_file
    import sfu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  flags_t d,
    output flags_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sub_flag_unit.sv
module sub_flag_unit
    import sfu_pkg::*;
#(
    parameter int W         = 32,
    parameter int MAX_SHIFT = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic [2:0]     op_code,
    input  logic           flag_en,
    output logic [W-1:0]   result,
    output logic           result_we,
    output logic [3:0]     flags_next,
    output logic           flags_we,
    output logic [3:0]     flags_q
);

    localparam int SHW = $clog2(MAX_SHIFT + 1);

    dec_t         dec;
    logic [W-1:0] minu;
    logic [W-1:0] subt;
    logic         bin;
    flags_t       nxt;
    flags_t       cur;

    sfu_decode u_dec (
        .op_code (op_code),
        .dec     (dec)
    );

    sfu_operand_prep #(
        .W         (W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_prep (
        .a     (opnd_a),
        .b     (opnd_b),
        .swap  (dec.swap),
        .shamt (SHW'(dec.shamt)),
        .minu  (minu),
        .subt  (subt)
    );

    assign bin = dec.use_cin & cur.c;

    sfu_sub_core #(
        .W (W)
    ) u_core (
        .minu (minu),
        .subt (subt),
        .bin  (bin),
        .diff (result),
        .flg  (nxt)
    );

    always_comb begin
        result_we  = dec.active & dec.wr_res;
        flags_we   = dec.active & (dec.flags_always | flag_en);
        flags_next = nxt;
        flags_q    = cur;
    end

    sfu_flag_file u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flags_we),
        .d     (nxt),
        .q     (cur)
    );

endmodule

// File: rtl/sub_flag_unit_chk.sv
module sub_flag_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [2:0]   op_code,
    input logic         flag_en,
    input logic         result_we,
    input logic [3:0]   flags_next,
    input logic         flags_we,
    input logic [3:0]   flags_q
);

    AST_WRITE_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code <= 3'd5) |-> result_we); // R1

    AST_CMP_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd6) |-> (flags_we && !result_we)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd7) |-> (!flags_we && !result_we)); // R6

    AST_EQUAL_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && (op_code == 3'd0 || op_code == 3'd6) && opnd_a == opnd_b)
        |-> (flags_next[3] && !flags_next[1] && !flags_next[0])); // R7

    AST_NOFLAG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (result_we && !flag_en) |-> !flags_we); // R10

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |=> (flags_q == $past(flags_next))); // R11

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |=> $stable(flags_q)); // R11

endmodule

bind sub_flag_unit sub_flag_unit_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .op_code    (op_code),
    .flag_en    (flag_en),
    .result_we  (result_we),
    .flags_next (flags_next),
    .flags_we   (flags_we),
    .flags_q    (flags_q)
);

// File: tb/sub_flag_unit_tb_top.sv
module sub_flag_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [2:0]  op_code;
    logic        flag_en;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags_next;
    logic        flags_we;
    logic [3:0]  flags_q;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    logic [3:0] mdl_flags;

    always #4 clk = ~clk;

    sub_flag_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .op_code    (op_code),
        .flag_en    (flag_en),
        .result     (result),
        .result_we  (result_we),
        .flags_next (flags_next),
        .flags_we   (flags_we),
        .flags_q    (flags_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference with 33-bit arithmetic
    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic cin, input logic fe,
                         output logic [31:0] r, output logic [3:0] f,
                         output logic rwe, output logic fwe);
        logic [31:0] m;
        logic [31:0] s;
        logic        bi;
        logic [32:0] d33;
        m = a; s = b; bi = 1'b0;
        case (op)
            3'd1: bi = cin;
            3'd2: s = b << 1;
            3'd3: s = b << 2;
            3'd4: s = b << 3;
            3'd5: begin m = b; s = a; end
            default: ;
        endcase
        d33 = {1'b0, m} - {1'b0, s} - {32'd0, bi};
        r   = d33[31:0];
        f[3] = (r == 32'd0);
        f[2] = r[31];
        f[1] = d33[32];
        f[0] = (m[31] != s[31]) && (r[31] != m[31]);
        rwe  = (op <= 3'd5);
        fwe  = (op == 3'd6) || ((op <= 3'd5) && fe);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic fe, input string req);
        logic [31:0] er;
        logic [3:0]  ef;
        logic        erwe;
        logic        efwe;
        model(op, a, b, mdl_flags[1], fe, er, ef, erwe, efwe);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; flag_en = fe;
        #2;
        chk(req, "result_we", {31'd0, result_we}, {31'd0, erwe});
        chk(req, "flags_we", {31'd0, flags_we}, {31'd0, efwe});
        if (erwe) chk(req, "result", result, er);
        if (efwe) chk(req, "flags_next", {28'd0, flags_next}, {28'd0, ef});
        @(posedge clk);
        #1;
        if (efwe) mdl_flags = ef;
        chk(req, "flags_q", {28'd0, flags_q}, {28'd0, mdl_flags});
    endtask

    task automatic t_reset;
        chk("R11", "flags_q after reset", {28'd0, flags_q}, 32'd0);
        chk("R6", "idle result_we", {31'd0, result_we}, 32'd0);
        chk("R6", "idle flags_we", {31'd0, flags_we}, 32'd0);
    endtask

    task automatic t_sub;
        run_op(3'd0, 32'd100, 32'd58, 1'b1, "R1");
        run_op(3'd0, 32'd7, 32'd7, 1'b1, "R7");
        run_op(3'd0, 32'd0, 32'd1, 1'b1, "R8");
        run_op(3'd0, 32'h8000_0000, 32'd1, 1'b1, "R9");
        run_op(3'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R9");
    endtask

    task automatic t_sbc_chain;
        run_op(3'd0, 32'd0, 32'd1, 1'b1, "R8");
        run_op(3'd1, 32'd5, 32'd2, 1'b1, "R2");
        run_op(3'd1, 32'd5, 32'd2, 1'b1, "R2");
        run_op(3'd1, 32'd0, 32'hFFFF_FFFF, 1'b1, "R2");
        run_op(3'd1, 32'd3, 32'd3, 1'b1, "R2");
    endtask

    task automatic t_scaled;
        run_op(3'd2, 32'd100, 32'd10, 1'b1, "R3");
        run_op(3'd3, 32'd100, 32'd25, 1'b1, "R3");
        run_op(3'd4, 32'h0000_0010, 32'hF000_0001, 1'b1, "R3");
        run_op(3'd4, 32'd0, 32'h2000_0000, 1'b1, "R3");
    endtask

    task automatic t_rsub;
        run_op(3'd5, 32'd10, 32'd3, 1'b1, "R4");
        run_op(3'd5, 32'd1, 32'h8000_0000, 1'b1, "R4");
    endtask

    task automatic t_cmp;
        run_op(3'd6, 32'd4, 32'd9, 1'b0, "R5");
        run_op(3'd6, 32'd9, 32'd9, 1'b0, "R5");
    endtask

    task automatic t_noflag;
        run_op(3'd0, 32'd0, 32'd1, 1'b1, "R10");
        run_op(3'd0, 32'd9, 32'd9, 1'b0, "R10");
        run_op(3'd5, 32'd9, 32'd1, 1'b0, "R10");
        run_op(3'd1, 32'd9, 32'd1, 1'b0, "R10");
    endtask

    task automatic t_idle;
        run_op(3'd7, 32'd1, 32'd2, 1'b1, "R6");
    endtask

    task automatic t_sweep;
        logic [31:0] x;
        x = 32'h1234_5678;
        for (int i = 0; i < 120; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            a = x;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            b = (i % 5 == 0) ? a : x;
            run_op(3'(i % 8), a, b, x[3], "R8 R9 sweep");
        end
    endtask

    initial begin
        mdl_flags = 4'd0;
        rst_n   = 1'b0;
        op_code = 3'd7;
        opnd_a  = '0;
        opnd_b  = '0;
        flag_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sub();
        t_sbc_chain();
        t_scaled();
        t_rsub();
        t_cmp();
        t_noflag();
        t_idle();
        t_sweep();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule